// File: doc/BRIEF.md
# Dual-User Protected Memory Bus Steering Controller

This block sits in the data path between two 16-bit user buses and one memory bus. The memory bus carries 16 data bits and 8 check bits. It reads the path-select input, the master-select input and the strobes of both users. From these it decides which bus is driven and with what. Each tri-state pad is modelled as a data-out and drive-enable pair.

In memory mode, a write stores the master's word together with freshly generated check bits. A read returns the stored word to the master, either corrected or raw, and raises a correctable or uncorrectable error flag. Instead of the word, a read can return a diagnostic word made of the syndrome and the stored check bits. The other user may listen to either kind of memory cycle. In transfer mode the memory bus stays idle, and a word moves from one user bus to the other in the direction that the master's read/write strobe sets.

All outputs are registered. Each output reflects the inputs sampled at the previous rising clock edge, so the whole block has one cycle of latency. Arbitration between the users happens outside the block.

Top module: `edac_steer_top`

## Requirements
- R1: While rst_n is low, every drive enable and both error flags are 0, and they go to 0 as soon as reset is asserted. Otherwise every output takes, at a rising edge, the value set by the inputs sampled at that edge.
- R2: A memory write is path_mem_i=1, master msel_n=0 and master rnw=0. On a memory write, md_o carries the master's data and md_drv_o=mc_drv_o=1, while the master's own bus is not driven. mc_o[j] is the XOR of the data bits i whose code column has bit j set, inverted for j in {2,3,7}. For data bits 0 to 15, the low six column bits are 0D,0E,1C,2C,0B,15,23,31,13,16,1A,32,25,29,2A,34 (hex). Column bit 6 is set for bits 7:0 and column bit 7 for bits 15:8.
- R3: A memory read is path_mem_i=1, master msel_n=0 and master rnw=1. On a memory read with diag_en_i=0, the master bus drives when its oe_n is 0. It drives the corrected word when fix_en_i=1 and md_i unchanged when fix_en_i=0.
- R4: The syndrome is the check bits regenerated from md_i XOR mc_i. A syndrome equal to data bit i's column sets corr_err_o, and with fix_en_i=1 it inverts bit i of the returned word.
- R5: A one-hot syndrome (a check-bit error) sets corr_err_o and leaves the data unchanged. Any other nonzero syndrome sets only uncorr_err_o, and the data is returned uncorrected. The two flags are never set together.
- R6: On a memory read with diag_en_i=1, the returned word is {syndrome[7:0], mc_i[7:0]}, with the syndrome in the high byte.
- R7: The non-master user drives during a memory read (the same word as the master) or a memory write (the written word) exactly when its own oe_n is 0.
- R8: With path_mem_i=1 and master msel_n=1, nothing is driven and both flags stay 0.
- R9: With path_mem_i=0, the memory buses are not driven. If the master's oe_n is 0, master rnw=1 makes the master bus drive the other user's data, and rnw=0 makes the other bus drive the master's data. If the master's oe_n is 1, neither user bus drives.
- R10: Outside memory reads both flags are 0, and fix_en_i and diag_en_i have no effect on any output.
- R11: The master's bus is never driven in a cycle when the memory bus is driven, and in transfer mode at most one user bus drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| path_mem_i | input | 1 | 1 = memory path, 0 = user-to-user path |
| master_b_i | input | 1 | 1 = user B is master, 0 = user A is master |
| fix_en_i | input | 1 | Correct single-bit data errors on reads |
| diag_en_i | input | 1 | Return syndrome/check word on reads |
| ua_rnw_i | input | 1 | User A read (1) / write (0) |
| ua_msel_n_i | input | 1 | User A memory select, active low |
| ua_oe_n_i | input | 1 | User A output enable, active low |
| ua_d_i | input | 16 | User A bus, pad input |
| ua_d_o | output | 16 | User A bus, pad output |
| ua_drv_o | output | 1 | User A pad drive enable |
| ub_rnw_i | input | 1 | User B read (1) / write (0) |
| ub_msel_n_i | input | 1 | User B memory select, active low |
| ub_oe_n_i | input | 1 | User B output enable, active low |
| ub_d_i | input | 16 | User B bus, pad input |
| ub_d_o | output | 16 | User B bus, pad output |
| ub_drv_o | output | 1 | User B pad drive enable |
| md_i | input | 16 | Memory data, pad input |
| md_o | output | 16 | Memory data, pad output |
| md_drv_o | output | 1 | Memory data drive enable |
| mc_i | input | 8 | Memory check bits, pad input |
| mc_o | output | 8 | Memory check bits, pad output |
| mc_drv_o | output | 1 | Memory check drive enable |
| corr_err_o | output | 1 | Correctable error seen on read |
| uncorr_err_o | output | 1 | Uncorrectable error seen on read |

## Verification
Two functions can fall in the same cycle. The first is a corrected memory read to the master together with the listener copy on the other bus. The second is a memory write together with its echo. The sweep drives every combination of path, master and strobe bits, so both users' enables are active at once in many cycles. At the same time, the memory word carries no error, a single data error, a single check error or a double error. Each bus's enable and value, and each flag, is compared against a bench model built from the requirements. The reads check that the listener receives exactly the same corrected, raw or diagnostic word as the master.

// File: rtl/edac_steer_pkg.sv
package edac_steer_pkg;

  localparam int DW = 16;
  localparam int CW = 8;

  // check positions whose parity is inverted (odd parity)
  localparam logic [CW-1:0] CHK_INV = 8'h8C;

  typedef enum logic [1:0] {
    SRC_RD = 2'd0,
    SRC_UA = 2'd1,
    SRC_UB = 2'd2
  } src_e;

  typedef struct packed {
    logic a_oe;
    src_e a_src;
    logic b_oe;
    src_e b_src;
    logic mem_oe;
    logic mem_from_b;
    logic rd_act;
  } steer_t;

  // code column of one data bit: six-bit pattern of weight three,
  // plus a byte-lane bit (6 for low byte, 7 for high byte)
  function automatic logic [CW-1:0] code_col(input int unsigned idx);
    logic [5:0] lo;
    case (idx)
      0:  lo = 6'h0D;
      1:  lo = 6'h0E;
      2:  lo = 6'h1C;
      3:  lo = 6'h2C;
      4:  lo = 6'h0B;
      5:  lo = 6'h15;
      6:  lo = 6'h23;
      7:  lo = 6'h31;
      8:  lo = 6'h13;
      9:  lo = 6'h16;
      10: lo = 6'h1A;
      11: lo = 6'h32;
      12: lo = 6'h25;
      13: lo = 6'h29;
      14: lo = 6'h2A;
      default: lo = 6'h34;
    endcase
    return {(idx >= 8), (idx < 8), lo};
  endfunction

endpackage

// File: rtl/edac_chk_gen.sv
module edac_chk_gen
  import edac_steer_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int CHK_W  = CW
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);

  for (genvar j = 0; j < CHK_W; j++) begin : g_chk
    logic [DATA_W-1:0] mask;
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam logic [CW-1:0] COL = code_col(i);
      assign mask[i] = COL[j];
    end
    assign chk_o[j] = (^(data_i & mask)) ^ CHK_INV[j];
  end

endmodule

// File: rtl/edac_syn_dec.sv
module edac_syn_dec
  import edac_steer_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int CHK_W  = CW
) (
  input  logic [DATA_W-1:0] md_i,
  input  logic [CHK_W-1:0]  mc_i,
  output logic [CHK_W-1:0]  syn_o,
  output logic [DATA_W-1:0] fixed_o,
  output logic              corr_o,
  output logic              uncorr_o
);

  logic [CHK_W-1:0]  regen;
  logic [DATA_W-1:0] flip;
  logic              chk_hit;

  edac_chk_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) regen_i (
    .data_i (md_i),
    .chk_o  (regen)
  );

  assign syn_o = regen ^ mc_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_match
    localparam logic [CW-1:0] COL = code_col(i);
    assign flip[i] = (syn_o == COL[CHK_W-1:0]);
  end

  assign chk_hit  = $onehot(syn_o);
  assign corr_o   = (|flip) | chk_hit;
  assign uncorr_o = (|syn_o) & ~corr_o;
  assign fixed_o  = md_i ^ flip;

endmodule

// File: rtl/edac_path_ctl.sv
module edac_path_ctl
  import edac_steer_pkg::*;
(
  input  logic   path_mem_i,
  input  logic   master_b_i,
  input  logic   ua_rnw_i,
  input  logic   ua_msel_n_i,
  input  logic   ua_oe_n_i,
  input  logic   ub_rnw_i,
  input  logic   ub_msel_n_i,
  input  logic   ub_oe_n_i,
  output steer_t steer_o
);

  logic m_rnw, m_msel_n, m_oe_n;
  logic mem_rd, mem_wr, xfer_go;

  always_comb begin
    m_rnw    = master_b_i ? ub_rnw_i    : ua_rnw_i;
    m_msel_n = master_b_i ? ub_msel_n_i : ua_msel_n_i;
    m_oe_n   = master_b_i ? ub_oe_n_i   : ua_oe_n_i;

    mem_rd  = path_mem_i & ~m_msel_n & m_rnw;
    mem_wr  = path_mem_i & ~m_msel_n & ~m_rnw;
    xfer_go = ~path_mem_i & ~m_oe_n;

    steer_o = '0;
    steer_o.rd_act     = mem_rd;
    steer_o.mem_oe     = mem_wr;
    steer_o.mem_from_b = master_b_i;

    // user A: receives on reads, echoes B's write, or is transfer target
    steer_o.a_oe = (mem_rd & ~ua_oe_n_i)
                 | (mem_wr & master_b_i & ~ua_oe_n_i)
                 | (xfer_go & (master_b_i ? ~m_rnw : m_rnw));
    steer_o.a_src = mem_rd ? SRC_RD : SRC_UB;

    // user B: mirror image
    steer_o.b_oe = (mem_rd & ~ub_oe_n_i)
                 | (mem_wr & ~master_b_i & ~ub_oe_n_i)
                 | (xfer_go & (master_b_i ? m_rnw : ~m_rnw));
    steer_o.b_src = mem_rd ? SRC_RD : SRC_UA;
  end

endmodule

// File: rtl/edac_steer_top.sv
module edac_steer_top
  import edac_steer_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int CHK_W  = CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              path_mem_i,
  input  logic              master_b_i,
  input  logic              fix_en_i,
  input  logic              diag_en_i,
  input  logic              ua_rnw_i,
  input  logic              ua_msel_n_i,
  input  logic              ua_oe_n_i,
  input  logic [DATA_W-1:0] ua_d_i,
  output logic [DATA_W-1:0] ua_d_o,
  output logic              ua_drv_o,
  input  logic              ub_rnw_i,
  input  logic              ub_msel_n_i,
  input  logic              ub_oe_n_i,
  input  logic [DATA_W-1:0] ub_d_i,
  output logic [DATA_W-1:0] ub_d_o,
  output logic              ub_drv_o,
  input  logic [DATA_W-1:0] md_i,
  output logic [DATA_W-1:0] md_o,
  output logic              md_drv_o,
  input  logic [CHK_W-1:0]  mc_i,
  output logic [CHK_W-1:0]  mc_o,
  output logic              mc_drv_o,
  output logic              corr_err_o,
  output logic              uncorr_err_o
);

  localparam int DIAG_W = 2 * CHK_W;

  steer_t            steer;
  logic [DATA_W-1:0] wr_word;
  logic [CHK_W-1:0]  wr_chk;
  logic [CHK_W-1:0]  syn;
  logic [DATA_W-1:0] fixed;
  logic              corr, uncorr;
  logic [DATA_W-1:0] rd_word;
  logic [DIAG_W-1:0] diag_word;

  logic [DATA_W-1:0] ua_d_nxt, ub_d_nxt, md_nxt;
  logic [CHK_W-1:0]  mc_nxt;
  logic              ua_drv_nxt, ub_drv_nxt, md_drv_nxt, mc_drv_nxt;
  logic              corr_nxt, uncorr_nxt;

  edac_path_ctl ctl_i (
    .path_mem_i  (path_mem_i),
    .master_b_i  (master_b_i),
    .ua_rnw_i    (ua_rnw_i),
    .ua_msel_n_i (ua_msel_n_i),
    .ua_oe_n_i   (ua_oe_n_i),
    .ub_rnw_i    (ub_rnw_i),
    .ub_msel_n_i (ub_msel_n_i),
    .ub_oe_n_i   (ub_oe_n_i),
    .steer_o     (steer)
  );

  assign wr_word = steer.mem_from_b ? ub_d_i : ua_d_i;

  edac_chk_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) gen_i (
    .data_i (wr_word),
    .chk_o  (wr_chk)
  );

  edac_syn_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) dec_i (
    .md_i     (md_i),
    .mc_i     (mc_i),
    .syn_o    (syn),
    .fixed_o  (fixed),
    .corr_o   (corr),
    .uncorr_o (uncorr)
  );

  assign diag_word = {syn, mc_i};

  always_comb begin
    if (diag_en_i)     rd_word = DATA_W'(diag_word);
    else if (fix_en_i) rd_word = fixed;
    else               rd_word = md_i;
  end

  // next-state
  always_comb begin
    unique case (steer.a_src)
      SRC_RD:  ua_d_nxt = rd_word;
      SRC_UB:  ua_d_nxt = ub_d_i;
      default: ua_d_nxt = ua_d_i;
    endcase
    unique case (steer.b_src)
      SRC_RD:  ub_d_nxt = rd_word;
      SRC_UA:  ub_d_nxt = ua_d_i;
      default: ub_d_nxt = ub_d_i;
    endcase
    ua_drv_nxt = steer.a_oe;
    ub_drv_nxt = steer.b_oe;
    md_nxt     = wr_word;
    mc_nxt     = wr_chk;
    md_drv_nxt = steer.mem_oe;
    mc_drv_nxt = steer.mem_oe;
    corr_nxt   = steer.rd_act & corr;
    uncorr_nxt = steer.rd_act & uncorr;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ua_d_o       <= '0;
      ub_d_o       <= '0;
      md_o         <= '0;
      mc_o         <= '0;
      ua_drv_o     <= 1'b0;
      ub_drv_o     <= 1'b0;
      md_drv_o     <= 1'b0;
      mc_drv_o     <= 1'b0;
      corr_err_o   <= 1'b0;
      uncorr_err_o <= 1'b0;
    end else begin
      ua_d_o       <= ua_d_nxt;
      ub_d_o       <= ub_d_nxt;
      md_o         <= md_nxt;
      mc_o         <= mc_nxt;
      ua_drv_o     <= ua_drv_nxt;
      ub_drv_o     <= ub_drv_nxt;
      md_drv_o     <= md_drv_nxt;
      mc_drv_o     <= mc_drv_nxt;
      corr_err_o   <= corr_nxt;
      uncorr_err_o <= uncorr_nxt;
    end
  end

endmodule

// File: rtl/edac_steer_chk.sv
module edac_steer_chk (
  input logic clk,
  input logic rst_n,
  input logic path_mem_i,
  input logic master_b_i,
  input logic ua_rnw_i,
  input logic ua_msel_n_i,
  input logic ub_rnw_i,
  input logic ub_msel_n_i,
  input logic ua_drv_o,
  input logic ub_drv_o,
  input logic md_drv_o,
  input logic mc_drv_o,
  input logic corr_err_o,
  input logic uncorr_err_o
);

  logic m_msel_n, m_rnw;
  assign m_msel_n = master_b_i ? ub_msel_n_i : ua_msel_n_i;
  assign m_rnw    = master_b_i ? ub_rnw_i    : ua_rnw_i;

  // R9
  xfer_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !path_mem_i |=> (!md_drv_o && !mc_drv_o));

  // R11
  xfer_single_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !path_mem_i |=> !(ua_drv_o && ub_drv_o));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (path_mem_i && m_msel_n) |=>
      (!ua_drv_o && !ub_drv_o && !md_drv_o && !mc_drv_o && !corr_err_o && !uncorr_err_o));

  // R10
  flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(path_mem_i && !m_msel_n && m_rnw) |=> (!corr_err_o && !uncorr_err_o));

  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(corr_err_o && uncorr_err_o));

  // R11
  no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    md_drv_o |-> ($past(master_b_i) ? !ub_drv_o : !ua_drv_o));

endmodule

bind edac_steer_top edac_steer_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .path_mem_i   (path_mem_i),
  .master_b_i   (master_b_i),
  .ua_rnw_i     (ua_rnw_i),
  .ua_msel_n_i  (ua_msel_n_i),
  .ub_rnw_i     (ub_rnw_i),
  .ub_msel_n_i  (ub_msel_n_i),
  .ua_drv_o     (ua_drv_o),
  .ub_drv_o     (ub_drv_o),
  .md_drv_o     (md_drv_o),
  .mc_drv_o     (mc_drv_o),
  .corr_err_o   (corr_err_o),
  .uncorr_err_o (uncorr_err_o)
);

// File: tb/edac_steer_top_tb_top.sv
module edac_steer_top_tb_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        path_mem_i, master_b_i, fix_en_i, diag_en_i;
  logic        ua_rnw_i, ua_msel_n_i, ua_oe_n_i;
  logic        ub_rnw_i, ub_msel_n_i, ub_oe_n_i;
  logic [15:0] ua_d_i, ub_d_i, md_i;
  logic [7:0]  mc_i;
  logic [15:0] ua_d_o, ub_d_o, md_o;
  logic [7:0]  mc_o;
  logic        ua_drv_o, ub_drv_o, md_drv_o, mc_drv_o, corr_err_o, uncorr_err_o;

  always #(CLK_P/2) clk = ~clk;

  edac_steer_top dut_i (
    .clk(clk), .rst_n(rst_n), .path_mem_i(path_mem_i), .master_b_i(master_b_i),
    .fix_en_i(fix_en_i), .diag_en_i(diag_en_i),
    .ua_rnw_i(ua_rnw_i), .ua_msel_n_i(ua_msel_n_i), .ua_oe_n_i(ua_oe_n_i),
    .ua_d_i(ua_d_i), .ua_d_o(ua_d_o), .ua_drv_o(ua_drv_o),
    .ub_rnw_i(ub_rnw_i), .ub_msel_n_i(ub_msel_n_i), .ub_oe_n_i(ub_oe_n_i),
    .ub_d_i(ub_d_i), .ub_d_o(ub_d_o), .ub_drv_o(ub_drv_o),
    .md_i(md_i), .md_o(md_o), .md_drv_o(md_drv_o),
    .mc_i(mc_i), .mc_o(mc_o), .mc_drv_o(mc_drv_o),
    .corr_err_o(corr_err_o), .uncorr_err_o(uncorr_err_o)
  );

  // low six bits of each data bit's code column (from R2)
  localparam logic [5:0] LO6 [16] = '{6'h0D, 6'h0E, 6'h1C, 6'h2C, 6'h0B, 6'h15, 6'h23, 6'h31,
                                     6'h13, 6'h16, 6'h1A, 6'h32, 6'h25, 6'h29, 6'h2A, 6'h34};

  typedef struct packed {
    logic        a_oe; logic [15:0] a_d;
    logic        b_oe; logic [15:0] b_d;
    logic        m_oe; logic [15:0] m_d; logic [7:0] c_d;
    logic        corr; logic        unc;
    logic [3:0]  req;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  function automatic logic [7:0] col_of(int i);
    return {(i >= 8) ? 1'b1 : 1'b0, (i < 8) ? 1'b1 : 1'b0, LO6[i]};
  endfunction

  function automatic logic [7:0] ref_chk(logic [15:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 16; i++)
      if (d[i]) c = c ^ col_of(i);
    return c ^ 8'h8C;  // positions 2,3,7 inverted (R2)
  endfunction

  task automatic check(input bit ok, input int req, input string what,
                       input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected result
  task automatic drive(input logic [9:0] ctl, input int s);
    exp_t        e;
    logic [15:0] good, md, fixed, rd;
    logic [7:0]  mc, syn;
    logic        corr, unc, m_rnw, m_msel_n, m_oe_n;
    @(negedge clk);
    good = 16'(s * 40503 + 7);
    md   = good;
    mc   = ref_chk(good);
    case (s % 5)
      1: md = md ^ (16'd1 << (s % 16));                        // single data error
      2: mc = mc ^ (8'd1 << (s % 8));                          // single check error
      3: md = md ^ (16'd3 << (s % 15));                        // double data error
      4: begin md = md ^ (16'd1 << (s % 16)); mc = mc ^ (8'd1 << ((s/3) % 8)); end
      default: ;
    endcase
    {diag_en_i, fix_en_i, ub_oe_n_i, ub_msel_n_i, ub_rnw_i,
     ua_oe_n_i, ua_msel_n_i, ua_rnw_i, master_b_i, path_mem_i} = ctl;
    ua_d_i = 16'(s * 4957 + 16'hA5C3);
    ub_d_i = 16'(s * 7919 + 16'h3C96);
    md_i = md;
    mc_i = mc;

    // reference decode (R4, R5)
    syn = ref_chk(md) ^ mc;
    fixed = md; corr = 1'b0;
    for (int i = 0; i < 16; i++)
      if (syn == col_of(i)) begin fixed[i] = ~fixed[i]; corr = 1'b1; end
    if ($countones(syn) == 1) corr = 1'b1;
    unc = (syn != 8'h00) && !corr;
    rd = diag_en_i ? {syn, mc} : (fix_en_i ? fixed : md);  // R3, R6

    m_rnw    = master_b_i ? ub_rnw_i    : ua_rnw_i;
    m_msel_n = master_b_i ? ub_msel_n_i : ua_msel_n_i;
    m_oe_n   = master_b_i ? ub_oe_n_i   : ua_oe_n_i;

    e = '0;
    if (path_mem_i) begin
      if (m_msel_n) e.req = 4'd8;                 // R8: idle
      else if (m_rnw) begin                       // R3 R7 read and listen
        e.req  = diag_en_i ? 4'd6 : (corr ? 4'd4 : (unc ? 4'd5 : 4'd3));
        e.a_oe = !ua_oe_n_i; e.a_d = rd;
        e.b_oe = !ub_oe_n_i; e.b_d = rd;
        e.corr = corr; e.unc = unc;
      end else begin                              // R2 R7 write and echo
        e.req  = 4'd2;
        e.m_oe = 1'b1;
        e.m_d  = master_b_i ? ub_d_i : ua_d_i;
        e.c_d  = ref_chk(e.m_d);
        if (master_b_i) begin e.a_oe = !ua_oe_n_i; e.a_d = ub_d_i; end
        else            begin e.b_oe = !ub_oe_n_i; e.b_d = ua_d_i; end
      end
    end else begin                                // R9 transfer
      e.req = 4'd9;
      if (!m_oe_n) begin
        if (m_rnw == master_b_i) begin e.b_oe = 1'b1; e.b_d = ua_d_i; end
        else                     begin e.a_oe = 1'b1; e.a_d = ub_d_i; end
      end
    end
    q.push_back(e);
  endtask

  // monitor: compare one cycle after the driver
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(ua_drv_o === e.a_oe, e.req, "ua_drv", 16'(ua_drv_o), 16'(e.a_oe));
      if (e.a_oe) check(ua_d_o === e.a_d, e.req, "ua_d", ua_d_o, e.a_d);
      check(ub_drv_o === e.b_oe, e.req, "ub_drv", 16'(ub_drv_o), 16'(e.b_oe));
      if (e.b_oe) check(ub_d_o === e.b_d, e.req, "ub_d", ub_d_o, e.b_d);
      check(md_drv_o === e.m_oe && mc_drv_o === e.m_oe, e.req, "mem_drv",
            16'({md_drv_o, mc_drv_o}), 16'({e.m_oe, e.m_oe}));
      if (e.m_oe) begin
        check(md_o === e.m_d, e.req, "md", md_o, e.m_d);
        check(mc_o === e.c_d, e.req, "mc", 16'(mc_o), 16'(e.c_d));
      end
      // R10: flags zero outside reads, R4/R5 on reads
      check(corr_err_o === e.corr && uncorr_err_o === e.unc, e.req, "flags",
            16'({corr_err_o, uncorr_err_o}), 16'({e.corr, e.unc}));
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {diag_en_i, fix_en_i, ub_oe_n_i, ub_msel_n_i, ub_rnw_i} = 5'b00_110;
    {ua_oe_n_i, ua_msel_n_i, ua_rnw_i, master_b_i, path_mem_i} = 5'b000_01; // A writes memory
    ua_d_i = 16'h1234; ub_d_i = 16'h5678; md_i = 16'h0; mc_i = 8'h0;
    repeat (3) @(negedge clk);
    // R1: reset holds every enable and flag low
    check({ua_drv_o, ub_drv_o, md_drv_o, mc_drv_o, corr_err_o, uncorr_err_o} === 6'b0,
          1, "reset_state", 16'({ua_drv_o, ub_drv_o, md_drv_o, mc_drv_o, corr_err_o, uncorr_err_o}), 16'h0);
    rst_n = 1'b1;

    // full sweep of path, master, strobes and modes, two data seeds
    for (int k = 0; k < 2048; k++) drive(k[9:0], k);
    repeat (2) @(negedge clk);

    // R1: reset asserted while a write is active clears outputs at once
    drive(10'b00_110_000_01, 3);
    @(posedge clk); #2;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check({ua_drv_o, ub_drv_o, md_drv_o, mc_drv_o} === 4'b0, 1, "async_reset",
          16'({ua_drv_o, ub_drv_o, md_drv_o, mc_drv_o}), 16'h0);
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule